// File: doc/BRIEF.md
# Status Register Write Protection Unit

This block holds the status byte of a serial memory controller and makes every write-permission decision for it. It keeps three volatile bits (write enable latch, a general flag and the busy bit) and three bits that would be nonvolatile in the part (the status-lock enable and two region-lock bits). The command decoder in front of it sends one-cycle pulses: set the write enable latch, clear the latch and the flag, set the flag, commit a status write with its data byte, commit an array write with the page start address, and the end of a write cycle. The live write-protect pin (active low) is sampled combinationally.

The block drives the status byte that a read-status command shifts out. It also drives two permission outputs that the controller consults. One permits a status write. The other permits an array write to the address currently presented. A commit that is permitted starts a write cycle. That cycle sets the busy bit and holds the pending status fields until the done pulse arrives. A commit that is denied changes nothing.

Top module: `wprot_top`

## Requirements
- R1: The status byte is bit 7 lock enable, bit 6 flag, bits 5 and 4 always 0, bit 3 region bit 1, bit 2 region bit 0, bit 1 write enable latch, bit 0 busy.
- R2: Reset (rstN low) clears the flag, the latch and the busy bit and keeps the lock enable and region bits. A cycle with porInit high loads the lock enable and region bits with 0.
- R3: cmdWelSet sets the latch. cmdFlbSet sets the flag. cmdWelFlbClr clears both the latch and the flag. Each change appears in the status byte one cycle after the pulse.
- R4: While the latch is 0, statusWrAllow and arrayWrAllow are 0 and no commit starts a write cycle.
- R5: statusWrAllow is 1 exactly when the latch is 1, the busy bit is 0, and the lock enable is not 1 while wpN is 0.
- R6: The two address MSBs against the region bits decide protection. Code 00 protects nothing. Code 01 protects the top quarter (MSBs 11). Code 10 protects the upper half (MSB 1). Code 11 protects every address. arrayWrAllow is the latch, and not busy, and not protected.
- R7: A permitted array commit sets the busy bit. A denied commit leaves busy at 0 and the latch unchanged.
- R8: A done pulse during a cycle clears busy and the latch. For a status cycle it also loads lock enable, flag and region bits from bits 7, 6, 3 and 2 of the committed byte. Bits 5 and 4 are ignored.
- R9: A status commit whose data bits 1:0 are not both 0 is rejected and starts no cycle.
- R10: wpN going low during a status cycle does not abort it. Once lock enable is 1 and wpN is low, later status writes are blocked until wpN returns high.
- R11: While busy, every command other than the done pulse is ignored.
- R12: A done pulse while not busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the volatile bits |
| porInit | input | 1 | Synchronous power-on load of the lock bits to 0 |
| cmdWelSet | input | 1 | Set write enable latch pulse |
| cmdWelFlbClr | input | 1 | Clear latch and flag pulse |
| cmdFlbSet | input | 1 | Set flag pulse |
| cmdStatusWr | input | 1 | Status write commit pulse |
| statusWrData | input | 8 | Byte for a status write commit |
| cmdArrayWr | input | 1 | Array write commit pulse |
| arrayAddr | input | ADDR_W | Address for the array permission query and the commit |
| cmdWrDone | input | 1 | Write cycle finished pulse |
| wpN | input | 1 | Write-protect pin, active low |
| statusOut | output | 8 | Status byte |
| statusWrAllow | output | 1 | A status write would be accepted |
| arrayWrAllow | output | 1 | An array write to arrayAddr would be accepted |

## Verification
The bench sweeps every address under each region code, both with the latch set and with it cleared. A decoder that was off by one quarter, or ignored the latch, would grant writes into a locked region. It walks all eight combinations of latch, lock enable and pin, which exposes any swap of the pin polarity. It drops the pin in the middle of a status cycle that sets the lock enable. The cycle must still land, and the next attempt must be refused. A design that sampled the pin at done time, or only at commit time, would do one or the other wrongly. It also checks that a denied array commit keeps the latch, that commands during a busy cycle are ignored, that a stray done pulse is ignored, and that a status byte with nonzero low bits is rejected.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic welSet;
    logic welClr;
    logic flbSet;
    logic flbClr;
    logic wipSet;
    logic wipClr;
    logic pendLoad;
    logic nvCommit;
  } strobe_t;

  // Protection from region code and the two address MSBs
  function automatic logic regionLocked(input logic [1:0] code, input logic [1:0] msbs);
    case (code)
      2'b01:   return (msbs == 2'b11);
      2'b10:   return msbs[1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/wprot_datapath.sv
module wprot_datapath
  import wprot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       porInit,
  input  strobe_t    stb,
  input  logic       pendIsStatusIn,
  input  logic [7:0] wrData,
  input  logic [1:0] addrMsbs,
  output logic       wel,
  output logic       wip,
  output logic       lockEn,
  output logic       pendIsStatus,
  output logic       addrLocked,
  output logic [7:0] statusByte
);

  logic       flb;
  logic [1:0] region;
  logic [3:0] pendFields;   // lockEn, flag, region1, region0
  logic       unusedBits;

  assign unusedBits = ^{wrData[5:4], wrData[1:0]};

  // Volatile bits, cleared by reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel          <= 1'b0;
      flb          <= 1'b0;
      wip          <= 1'b0;
      pendIsStatus <= 1'b0;
      pendFields   <= '0;
    end else begin
      if (stb.welClr)      wel <= 1'b0;
      else if (stb.welSet) wel <= 1'b1;

      if (stb.nvCommit)    flb <= pendFields[2];
      else if (stb.flbClr) flb <= 1'b0;
      else if (stb.flbSet) flb <= 1'b1;

      if (stb.wipSet)      wip <= 1'b1;
      else if (stb.wipClr) wip <= 1'b0;

      if (stb.pendLoad) begin
        pendIsStatus <= pendIsStatusIn;
        pendFields   <= {wrData[7], wrData[6], wrData[3], wrData[2]};
      end
    end
  end

  // Lock bits survive reset; only power-on init or a finished status cycle moves them
  always_ff @(posedge clk) begin
    if (porInit) begin
      lockEn <= 1'b0;
      region <= 2'b00;
    end else if (stb.nvCommit) begin
      lockEn <= pendFields[3];
      region <= pendFields[1:0];
    end
  end

  assign addrLocked = regionLocked(region, addrMsbs);
  assign statusByte = {lockEn, flb, 2'b00, region, wel, wip};

endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
(
  input  logic       cmdWelSet,
  input  logic       cmdWelFlbClr,
  input  logic       cmdFlbSet,
  input  logic       cmdStatusWr,
  input  logic [1:0] statusLowBits,
  input  logic       cmdArrayWr,
  input  logic       cmdWrDone,
  input  logic       wpN,
  input  logic       wel,
  input  logic       wip,
  input  logic       lockEn,
  input  logic       pendIsStatus,
  input  logic       addrLocked,
  output strobe_t    stb,
  output logic       pendIsStatusOut,
  output logic       statusWrAllow,
  output logic       arrayWrAllow
);

  logic romMode;
  logic statusGo;
  logic arrayGo;

  assign romMode       = lockEn && !wpN;
  assign statusWrAllow = wel && !wip && !romMode;
  assign arrayWrAllow  = wel && !wip && !addrLocked;

  assign statusGo = cmdStatusWr && !cmdArrayWr && statusWrAllow && (statusLowBits == 2'b00);
  assign arrayGo  = cmdArrayWr && !cmdStatusWr && arrayWrAllow;
  assign pendIsStatusOut = statusGo;

  always_comb begin
    stb = '0;
    if (wip) begin
      if (cmdWrDone) begin
        stb.wipClr   = 1'b1;
        stb.welClr   = 1'b1;
        stb.nvCommit = pendIsStatus;
      end
    end else if (statusGo || arrayGo) begin
      stb.wipSet   = 1'b1;
      stb.pendLoad = 1'b1;
    end else begin
      stb.welSet = cmdWelSet;
      stb.welClr = cmdWelFlbClr;
      stb.flbSet = cmdFlbSet;
      stb.flbClr = cmdWelFlbClr;
    end
  end

endmodule

// File: rtl/wprot_top.sv
module wprot_top
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porInit,
  input  logic              cmdWelSet,
  input  logic              cmdWelFlbClr,
  input  logic              cmdFlbSet,
  input  logic              cmdStatusWr,
  input  logic [7:0]        statusWrData,
  input  logic              cmdArrayWr,
  input  logic [ADDR_W-1:0] arrayAddr,
  input  logic              cmdWrDone,
  input  logic              wpN,
  output logic [7:0]        statusOut,
  output logic              statusWrAllow,
  output logic              arrayWrAllow
);

  localparam int MSB_HI = ADDR_W - 1;
  localparam int MSB_LO = ADDR_W - 2;

  strobe_t    stb;
  logic       wel, wip, lockEn, pendIsStatus, addrLocked, pendIsStatusNew;
  logic [1:0] addrMsbs;

  generate
    if (ADDR_W > 2) begin : g_lowAddr
      logic unusedAddr;
      assign unusedAddr = ^arrayAddr[MSB_LO-1:0];
    end
  endgenerate

  assign addrMsbs = arrayAddr[MSB_HI:MSB_LO];

  wprot_ctrl ctrl_i (
    .cmdWelSet      (cmdWelSet),
    .cmdWelFlbClr   (cmdWelFlbClr),
    .cmdFlbSet      (cmdFlbSet),
    .cmdStatusWr    (cmdStatusWr),
    .statusLowBits  (statusWrData[1:0]),
    .cmdArrayWr     (cmdArrayWr),
    .cmdWrDone      (cmdWrDone),
    .wpN            (wpN),
    .wel            (wel),
    .wip            (wip),
    .lockEn         (lockEn),
    .pendIsStatus   (pendIsStatus),
    .addrLocked     (addrLocked),
    .stb            (stb),
    .pendIsStatusOut(pendIsStatusNew),
    .statusWrAllow  (statusWrAllow),
    .arrayWrAllow   (arrayWrAllow)
  );

  wprot_datapath dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .porInit       (porInit),
    .stb           (stb),
    .pendIsStatusIn(pendIsStatusNew),
    .wrData        (statusWrData),
    .addrMsbs      (addrMsbs),
    .wel           (wel),
    .wip           (wip),
    .lockEn        (lockEn),
    .pendIsStatus  (pendIsStatus),
    .addrLocked    (addrLocked),
    .statusByte    (statusOut)
  );

endmodule

// File: rtl/wprot_checker.sv
module wprot_checker (
  input logic       clk,
  input logic       rstN,
  input logic       porInit,
  input logic       cmdStatusWr,
  input logic       cmdArrayWr,
  input logic       cmdWrDone,
  input logic       wpN,
  input logic [7:0] statusOut,
  input logic       statusWrAllow,
  input logic       arrayWrAllow
);

  AST_ZERO_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[5:4] == 2'b00); // R1

  AST_LATCH_GATES: assert property (@(posedge clk) disable iff (!rstN)
    !statusOut[1] |-> (!statusWrAllow && !arrayWrAllow)); // R4

  AST_NO_CYCLE_WITHOUT_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (!statusOut[1] && !statusOut[0]) |=> !statusOut[0]); // R4

  AST_ROM_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[7] && !wpN) |-> !statusWrAllow); // R5

  AST_ARRAY_DENY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdArrayWr && !cmdStatusWr && !arrayWrAllow && !statusOut[0]) |=> !statusOut[0]); // R7

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrDone && statusOut[0]) |=> (!statusOut[0] && !statusOut[1])); // R8

  AST_LOCK_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdWrDone && !porInit) |=> $stable({statusOut[7], statusOut[3:2]})); // R8

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[0] |-> (!statusWrAllow && !arrayWrAllow)); // R11

  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrDone && !statusOut[0] && !cmdStatusWr && !cmdArrayWr) |=> !statusOut[0]); // R12

endmodule

bind wprot_top wprot_checker chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .porInit      (porInit),
  .cmdStatusWr  (cmdStatusWr),
  .cmdArrayWr   (cmdArrayWr),
  .cmdWrDone    (cmdWrDone),
  .wpN          (wpN),
  .statusOut    (statusOut),
  .statusWrAllow(statusWrAllow),
  .arrayWrAllow (arrayWrAllow)
);

// File: tb/wprot_top_tb_top.sv
`timescale 1ns/1ps
module wprot_top_tb_top;

  localparam int ADDR_W = 11;
  localparam int NADDR  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0, porInit = 1'b0;
  logic cmdWelSet = 0, cmdWelFlbClr = 0, cmdFlbSet = 0, cmdStatusWr = 0, cmdArrayWr = 0, cmdWrDone = 0;
  logic [7:0] statusWrData = '0;
  logic [ADDR_W-1:0] arrayAddr = '0;
  logic wpN = 1'b1;
  logic [7:0] statusOut;
  logic statusWrAllow, arrayWrAllow;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wprot_top #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .porInit(porInit),
    .cmdWelSet(cmdWelSet), .cmdWelFlbClr(cmdWelFlbClr), .cmdFlbSet(cmdFlbSet),
    .cmdStatusWr(cmdStatusWr), .statusWrData(statusWrData),
    .cmdArrayWr(cmdArrayWr), .arrayAddr(arrayAddr), .cmdWrDone(cmdWrDone),
    .wpN(wpN), .statusOut(statusOut),
    .statusWrAllow(statusWrAllow), .arrayWrAllow(arrayWrAllow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one-cycle pulse; inputs change at negedge, result visible at the next negedge
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: cmdWelSet = 1;
      1: cmdWelFlbClr = 1;
      2: cmdFlbSet = 1;
      3: cmdStatusWr = 1;
      4: cmdArrayWr = 1;
      5: cmdWrDone = 1;
      default: porInit = 1;
    endcase
    @(negedge clk);
    {cmdWelSet, cmdWelFlbClr, cmdFlbSet, cmdStatusWr, cmdArrayWr, cmdWrDone, porInit} = '0;
  endtask

  task automatic progStatus(input logic [7:0] d);
    statusWrData = d;
    pulse(0); pulse(3); pulse(5);
  endtask

  function automatic logic locked(input int code, input int a);
    case (code)
      1: return a >= (NADDR * 3) / 4;
      2: return a >= NADDR / 2;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #1000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    porInit = 1;
    repeat (3) @(negedge clk);
    porInit = 0; rstN = 1;
    @(negedge clk);
    chk("R2 power-on status", statusOut, 8'h00);
    chk("R4 reset status allow", statusWrAllow, 0);

    // R3 latch and flag
    pulse(0); chk("R3 welSet", statusOut, 8'h02);
    pulse(2); chk("R3 flbSet", statusOut, 8'h42);
    pulse(1); chk("R3 clear both", statusOut, 8'h00);

    // R8 field load, bits 5:4 ignored
    progStatus(8'hFC);
    chk("R8 R1 status fields", statusOut, 8'hCC);
    rstN = 0; @(negedge clk); rstN = 1; @(negedge clk);
    chk("R2 reset keeps lock bits", statusOut, 8'h8C);
    pulse(6); chk("R2 porInit clears lock bits", statusOut, 8'h00);

    // R9 low bits nonzero rejected
    pulse(0); statusWrData = 8'h01; pulse(3);
    chk("R9 bad low bits no cycle", statusOut, 8'h02);
    statusWrData = 8'h02; pulse(3);
    chk("R9 bad low bits no cycle", statusOut, 8'h02);
    pulse(1);

    // R6 sweep every address for every region code, latch on and off
    for (int code = 0; code < 4; code++) begin
      progStatus(8'(code << 2));
      chk("R6 region code set", statusOut, 8'(code << 2));
      for (int a = 0; a < NADDR; a++) begin
        arrayAddr = ADDR_W'(a); #0.5;
        chk("R4 array deny without latch", arrayWrAllow, 0);
      end
      pulse(0);
      for (int a = 0; a < NADDR; a++) begin
        arrayAddr = ADDR_W'(a); #0.5;
        chk("R6 array permission", arrayWrAllow, !locked(code, a));
      end
      @(negedge clk);
      pulse(1);
    end

    // R5 all latch/lock/pin combinations
    for (int le = 0; le < 2; le++)
      for (int w = 0; w < 2; w++)
        for (int p = 0; p < 2; p++) begin
          wpN = 1; progStatus(8'(le << 7));
          if (w) pulse(0);
          @(negedge clk); wpN = p[0]; #0.5;
          chk("R5 status permission", statusWrAllow, w && !(le && !p));
          @(negedge clk);
        end
    wpN = 1; progStatus(8'h00);

    // R7 denied commit keeps latch; R11 busy; R12 stray done
    progStatus(8'h04);
    pulse(0); arrayAddr = 11'h600; pulse(4);
    chk("R7 denied commit", statusOut, 8'h06);
    arrayAddr = 11'h5FF; pulse(4);
    chk("R7 accepted commit", statusOut, 8'h07);
    #0.5 chk("R11 busy blocks array", arrayWrAllow, 0);
    pulse(1); pulse(2);
    chk("R11 commands ignored while busy", statusOut, 8'h07);
    statusWrData = 8'h0C; pulse(3);
    pulse(5); chk("R8 done clears busy and latch", statusOut, 8'h04);
    pulse(5); chk("R12 idle done ignored", statusOut, 8'h04);

    // R10 pin drop mid-cycle
    pulse(0); statusWrData = 8'h80; pulse(3);
    @(negedge clk); wpN = 0;
    pulse(5); chk("R10 cycle not aborted", statusOut, 8'h80);
    pulse(0); #0.5 chk("R10 later status write blocked", statusWrAllow, 0);
    statusWrData = 8'h00; pulse(3);
    chk("R10 blocked commit no cycle", statusOut, 8'h82);
    @(negedge clk); wpN = 1; #0.5
    chk("R10 pin high re-enables", statusWrAllow, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule